// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits between instruction memory and the register file of a small sequential processor. Each cycle it receives the program counter and a six-byte window of instruction bytes starting at that address. It splits out the opcode and function nibbles, the two register specifiers and a 32-bit little-endian constant. It also computes the address of the next sequential instruction. Instructions are 1, 2, 5 or 6 bytes long, and the offset of the constant moves by one byte depending on whether a register byte is present.

The block also flags opcodes that do not belong to the instruction set. It chooses the register-file selections for both read ports (A, B) and both write destinations: E for the ALU result and M for the memory result. Several opcodes use the stack pointer without naming it. Register ID 8 means "no register" on every selector.

The block is purely combinational. There is no state machine, because every output follows from the current window.

Top module: `fetch_decoder`

## Requirements
- R1: `icode` equals window byte 0 bits [7:4] and `ifun` equals byte 0 bits [3:0], for every value of byte 0. Byte 0 is `inst_bytes[7:0]` and byte k is `inst_bytes[8k+7:8k]`.
- R2: Opcodes 0x0 to 0xB are legal: nop 0, halt 1, rrmovl 2, irmovl 3, rmmovl 4, mrmovl 5, OPl 6, jXX 7, call 8, ret 9, pushl A, popl B. Opcodes 0xC to 0xF drive `instr_valid` low. They also force rA, rB, srcA, srcB, dstE and dstM to 8, valC to 0 and valP to PC+1.
- R3: Opcodes 2, 3, 4, 5, 6, A and B carry a register byte: `rA` is byte 1 bits [7:4] and `rB` is byte 1 bits [3:0]. All other opcodes report 8 on both.
- R4: irmovl, rmmovl and mrmovl take `valC` from bytes 2..5, with byte 2 as the least significant byte.
- R5: jXX and call take `valC` from bytes 1..4, with byte 1 as the least significant byte. Every other opcode reports `valC` = 0.
- R6: `valP` is PC+1 for nop, halt, ret and illegal opcodes; PC+2 for rrmovl, OPl, pushl and popl; PC+5 for jXX and call; PC+6 for irmovl, rmmovl and mrmovl. The sum wraps modulo 2^32.
- R7: `srcA` is rA for rrmovl, rmmovl, OPl and pushl; 4 (stack pointer) for popl and ret; otherwise 8.
- R8: `srcB` is rB for OPl, rmmovl and mrmovl; 4 for pushl, popl, call and ret; otherwise 8.
- R9: `dstE` is rB for rrmovl, irmovl and OPl; 4 for pushl, popl, call and ret; otherwise 8.
- R10: `dstM` is rA for mrmovl and popl, and 8 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the first window byte |
| inst_bytes | input | 48 | Six instruction bytes, byte 0 in the low bits |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| rA | output | 4 | First register specifier, or 8 |
| rB | output | 4 | Second register specifier, or 8 |
| valC | output | 32 | Constant word, or 0 |
| valP | output | 32 | Address of the next sequential instruction |
| instr_valid | output | 1 | High for a legal opcode |
| srcA | output | 4 | Read port A selection |
| srcB | output | 4 | Read port B selection |
| dstE | output | 4 | ALU-result write selection |
| dstM | output | 4 | Memory-result write selection |

## Verification
Two functions can land on the same register in one evaluation. A popl whose named register is the stack pointer drives srcA, srcB, dstE and dstM to 4 together. A push or pop that names register 4 explicitly overlaps the implicit stack use in the same way. The bench sweeps every byte-0 value against several register bytes, including those that name register 4. Each selector is judged separately against an arithmetic model. Constant extraction and the wrapping next-PC sum are also provoked together, by placing 5- and 6-byte instructions at addresses just below 2^32.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

    localparam logic [3:0] OP_NOP   = 4'h0;
    localparam logic [3:0] OP_HALT  = 4'h1;
    localparam logic [3:0] OP_RRMOV = 4'h2;
    localparam logic [3:0] OP_IRMOV = 4'h3;
    localparam logic [3:0] OP_RMMOV = 4'h4;
    localparam logic [3:0] OP_MRMOV = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JUMP  = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;

    typedef struct packed {
        logic legal;
        logic has_reg;
        logic has_const;
    } fmt_t;

endpackage

// File: rtl/fdec_classify.sv
module fdec_classify
    import fdec_pkg::*;
(
    input  logic [3:0] op,
    output fmt_t       fmt
);

    always_comb begin
        fmt = '0;
        unique case (op)
            OP_NOP, OP_HALT, OP_RET:       fmt = '{legal: 1'b1, has_reg: 1'b0, has_const: 1'b0};
            OP_RRMOV, OP_ALU,
            OP_PUSH, OP_POP:               fmt = '{legal: 1'b1, has_reg: 1'b1, has_const: 1'b0};
            OP_IRMOV, OP_RMMOV, OP_MRMOV:  fmt = '{legal: 1'b1, has_reg: 1'b1, has_const: 1'b1};
            OP_JUMP, OP_CALL:              fmt = '{legal: 1'b1, has_reg: 1'b0, has_const: 1'b1};
            default:                       fmt = '0;
        endcase
    end

    always_comb begin
        assert_const_needs_legal_R2: assert (fmt.legal || (!fmt.has_reg && !fmt.has_const))
            else $error("illegal opcode classified with operand bytes");
    end

endmodule

// File: rtl/fdec_align.sv
module fdec_align
    import fdec_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int WORD_W  = 32,
    parameter int REG_W   = 4,
    parameter int NONE_ID = 8
) (
    input  logic [PC_W-1:0]             pc,
    input  logic [(2+WORD_W/8)*8-1:0]   window,
    input  fmt_t                        fmt,
    output logic [REG_W-1:0]            ra,
    output logic [REG_W-1:0]            rb,
    output logic [WORD_W-1:0]           valc,
    output logic [PC_W-1:0]             valp
);

    localparam int CB       = WORD_W / 8;
    localparam int LEN_W    = 4;
    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

    logic [LEN_W-1:0] len;

    always_comb begin
        ra = NONE;
        rb = NONE;
        if (fmt.has_reg) begin
            ra = window[15:12];
            rb = window[11:8];
        end
    end

    for (genvar k = 0; k < CB; k++) begin : g_cbyte
        always_comb begin
            if (!fmt.has_const)
                valc[k*8 +: 8] = 8'h00;
            else if (fmt.has_reg)
                valc[k*8 +: 8] = window[(2+k)*8 +: 8];
            else
                valc[k*8 +: 8] = window[(1+k)*8 +: 8];
        end
    end

    always_comb begin
        len = LEN_W'(1);
        if (fmt.has_reg)   len = len + LEN_W'(1);
        if (fmt.has_const) len = len + LEN_W'(CB);
    end

    assign valp = pc + PC_W'(len);

    always_comb begin
        assert_len_R6: assert ((valp - pc) == PC_W'(1) || (valp - pc) == PC_W'(2) ||
                               (valp - pc) == PC_W'(1+CB) || (valp - pc) == PC_W'(2+CB))
            else $error("next-PC step out of range");
        assert_regbyte_R3: assert (fmt.has_reg || (ra == NONE && rb == NONE))
            else $error("register fields leak without register byte");
        assert_const_R5: assert (fmt.has_const || valc == '0)
            else $error("constant present without constant field");
    end

endmodule

// File: rtl/fdec_ports.sv
module fdec_ports
    import fdec_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int NONE_ID = 8,
    parameter int SP_ID   = 4
) (
    input  logic [3:0]       op,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rb,
    output logic [REG_W-1:0] sel_a,
    output logic [REG_W-1:0] sel_b,
    output logic [REG_W-1:0] wr_e,
    output logic [REG_W-1:0] wr_m
);

    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);
    localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);

    always_comb begin
        sel_a = NONE;
        sel_b = NONE;
        wr_e  = NONE;
        wr_m  = NONE;
        unique case (op)
            OP_RRMOV: begin sel_a = ra;                 wr_e = rb; end
            OP_IRMOV: begin                             wr_e = rb; end
            OP_RMMOV: begin sel_a = ra; sel_b = rb;                end
            OP_MRMOV: begin             sel_b = rb;     wr_m = ra; end
            OP_ALU:   begin sel_a = ra; sel_b = rb;     wr_e = rb; end
            OP_CALL:  begin             sel_b = SP;     wr_e = SP; end
            OP_RET:   begin sel_a = SP; sel_b = SP;     wr_e = SP; end
            OP_PUSH:  begin sel_a = ra; sel_b = SP;     wr_e = SP; end
            OP_POP:   begin sel_a = SP; sel_b = SP;     wr_e = SP; wr_m = ra; end
            default:  begin end
        endcase
    end

    always_comb begin
        assert_stack_pair_R8: assert ((sel_b == SP && op != OP_ALU && op != OP_RMMOV && op != OP_MRMOV)
                                      -> (wr_e == SP))
            else $error("implicit stack read without stack update");
        assert_dstm_R10: assert ((wr_m == NONE) || op == OP_MRMOV || op == OP_POP)
            else $error("memory write-back on wrong opcode");
    end

endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
    import fdec_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int WORD_W  = 32,
    parameter int REG_W   = 4,
    parameter int NONE_ID = 8,
    parameter int SP_ID   = 4,
    localparam int WIN_W  = (2 + WORD_W/8) * 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [WIN_W-1:0]  inst_bytes,
    output logic [3:0]        icode,
    output logic [3:0]        ifun,
    output logic [REG_W-1:0]  rA,
    output logic [REG_W-1:0]  rB,
    output logic [WORD_W-1:0] valC,
    output logic [PC_W-1:0]   valP,
    output logic              instr_valid,
    output logic [REG_W-1:0]  srcA,
    output logic [REG_W-1:0]  srcB,
    output logic [REG_W-1:0]  dstE,
    output logic [REG_W-1:0]  dstM
);

    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

    fmt_t fmt;

    assign icode       = inst_bytes[7:4];
    assign ifun        = inst_bytes[3:0];
    assign instr_valid = fmt.legal;

    fdec_classify u_classify (
        .op  (icode),
        .fmt (fmt)
    );

    fdec_align #(
        .PC_W(PC_W), .WORD_W(WORD_W), .REG_W(REG_W), .NONE_ID(NONE_ID)
    ) u_align (
        .pc     (pc),
        .window (inst_bytes),
        .fmt    (fmt),
        .ra     (rA),
        .rb     (rB),
        .valc   (valC),
        .valp   (valP)
    );

    fdec_ports #(
        .REG_W(REG_W), .NONE_ID(NONE_ID), .SP_ID(SP_ID)
    ) u_ports (
        .op    (icode),
        .ra    (rA),
        .rb    (rB),
        .sel_a (srcA),
        .sel_b (srcB),
        .wr_e  (dstE),
        .wr_m  (dstM)
    );

    always_comb begin
        assert_illegal_quiet_R2: assert (instr_valid ||
            (srcA == NONE && srcB == NONE && dstE == NONE && dstM == NONE &&
             valP == pc + PC_W'(1)))
            else $error("illegal opcode selects registers");
        assert_split_R1: assert ({icode, ifun} == inst_bytes[7:0])
            else $error("opcode split mismatch");
    end

endmodule

// File: tb/fetch_decoder_test.sv
module fetch_decoder_test;

    logic        clk = 1'b0;
    logic [31:0] pc;
    logic [47:0] inst_bytes;
    logic [3:0]  icode, ifun, rA, rB, srcA, srcB, dstE, dstM;
    logic [31:0] valC, valP;
    logic        instr_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    fetch_decoder uut (
        .pc(pc), .inst_bytes(inst_bytes),
        .icode(icode), .ifun(ifun), .rA(rA), .rB(rB),
        .valC(valC), .valP(valP), .instr_valid(instr_valid),
        .srcA(srcA), .srcB(srcB), .dstE(dstE), .dstM(dstM)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h pc=%h act=%h exp=%h", req, inst_bytes[7:0], pc, act, exp);
        end
    endtask

    // Independent model, built from the requirement lists.
    task automatic run_case(input logic [31:0] p, input logic [47:0] w);
        logic [3:0] op, er_a, er_b, e_sa, e_sb, e_de, e_dm;
        logic [31:0] e_c, len;
        bit legal, regb, cnst;
        @(posedge clk);
        pc = p;
        inst_bytes = w;
        @(negedge clk);
        op    = w[7:4];
        legal = (op <= 4'hB);
        regb  = (op == 2 || op == 3 || op == 4 || op == 5 || op == 6 || op == 4'hA || op == 4'hB);
        cnst  = (op == 3 || op == 4 || op == 5 || op == 7 || op == 8);
        er_a  = regb ? w[15:12] : 4'd8;
        er_b  = regb ? w[11:8]  : 4'd8;
        if (op == 3 || op == 4 || op == 5) e_c = w[47:16];
        else if (op == 7 || op == 8)       e_c = w[39:8];
        else                               e_c = 32'h0;
        len = 1 + (regb ? 1 : 0) + (cnst ? 4 : 0);
        e_sa = (op == 2 || op == 4 || op == 6 || op == 4'hA) ? er_a :
               (op == 4'hB || op == 9) ? 4'd4 : 4'd8;
        e_sb = (op == 6 || op == 4 || op == 5) ? er_b :
               (op == 4'hA || op == 4'hB || op == 8 || op == 9) ? 4'd4 : 4'd8;
        e_de = (op == 2 || op == 3 || op == 6) ? er_b :
               (op == 4'hA || op == 4'hB || op == 8 || op == 9) ? 4'd4 : 4'd8;
        e_dm = (op == 5 || op == 4'hB) ? er_a : 4'd8;
        chk("R1 icode", 32'(icode), 32'(w[7:4]));
        chk("R1 ifun",  32'(ifun),  32'(w[3:0]));
        chk("R2 instr_valid", 32'(instr_valid), 32'(legal));
        chk("R3 rA", 32'(rA), 32'(er_a));
        chk("R3 rB", 32'(rB), 32'(er_b));
        chk(regb ? "R4 valC" : "R5 valC", valC, e_c);
        chk("R6 valP", valP, p + len);
        chk("R7 srcA", 32'(srcA), 32'(e_sa));
        chk("R8 srcB", 32'(srcB), 32'(e_sb));
        chk("R9 dstE", 32'(dstE), 32'(e_de));
        chk("R10 dstM", 32'(dstM), 32'(e_dm));
    endtask

    initial begin
        logic [31:0] pcs [4];
        logic [47:0] tails [4];
        pc = '0;
        inst_bytes = '0;
        pcs[0] = 32'h0000_0000; pcs[1] = 32'h0000_1234;
        pcs[2] = 32'hFFFF_FFFC; pcs[3] = 32'hFFFF_FFFF;
        tails[0] = 48'h44332211_0F00;   // rB = 15 no-register style, rA = 0
        tails[1] = 48'hDEADBEEF_4400;   // both fields name the stack pointer
        tails[2] = 48'h01020304_8400;   // rA=8, rB=4
        tails[3] = 48'hA5C3_7E19_3700;  // arbitrary fields
        // Quiescent state: all-zero window decodes as nop at address 0 (R2, R6).
        run_case(32'h0, 48'h0);
        for (int t = 0; t < 4; t++) begin
            for (int q = 0; q < 4; q++) begin
                for (int b0 = 0; b0 < 256; b0++) begin
                    run_case(pcs[q], {tails[t][47:8], 8'(b0)});
                end
            end
        end
        // popl with rA = stack pointer: all four selectors on 4 together (R7..R10).
        run_case(32'h100, 48'h0000_0000_48B0);
        chk("R10 popl sp", 32'(dstM), 32'd4);
        chk("R7 popl sp",  32'(srcA), 32'd4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule